// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sorts CPU addresses into three programmable windows: one I/O window and two memory windows. Each window has a lower-bound register and an upper-bound register. Both count in 2 MiB units and are written over a simple word-addressed 32-bit register bus. Every valid write to either bound recomputes a committed mapping for that window, made of a base unit and a length in units. A combinational comparator then checks the incoming CPU address against every committed mapping. It reports at most one winning window and the byte offset of the address inside that window.

The lower-bound register holds more bits than the comparison needs. The bits above the CPU address width are stored but do not reach the base. Bits 7 and up do not take part in the validity check or the length. A write to a lower bound also loads a read-only remap copy of that write. A write that leaves the window inverted, with the masked lower bound above the upper bound, is still stored in the register. The committed mapping does not change.

Top module: `addr_window_decoder`

## Requirements
- R1: Register words are selected by reg_addr_i[3:2] = window (0 I/O, 1 memory 0, 2 memory 1) and reg_addr_i[1:0] = field (0 lower bound, 1 upper bound, 2 remap). After reset they read: I/O 0x80/0x0F/0x80, memory 0 0x90/0x1F/0x90, memory 1 0x790/0x1F/0x790.
- R2: A lower-bound write stores wdata & 0x7FFF. An upper-bound write stores wdata & 0x7F.
- R3: A lower-bound write loads the remap word with wdata & 0x7FF. Writes to the remap field itself are ignored.
- R4: A committed window starts at lower[10:0] << 21 and spans ((upper + 1) − (lower & 0x7F)) << 21 bytes. Lower-bound bits 7..14 do not affect the length.
- R5: When cpu_addr_i lies in [start, start + span), the window's bit in hit_o is set (bit 0 I/O, bit 1 memory 0, bit 2 memory 1) and offset_o = cpu_addr_i − start. The span may reach the top of the 32-bit space.
- R6: A write to either bound after which (lower & 0x7F) > upper updates the register but keeps the previous committed mapping.
- R7: When windows overlap, hit_o names only one window, in the order I/O, then memory 0, then memory 1.
- R8: Read data is registered and appears on the cycle after reg_re_i. It holds while no read is issued. Unused fields and the unused window slot read zero. With no hit, hit_o and offset_o are zero.
- R9: A valid write to either bound changes the mapping from the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | One-cycle write strobe |
| reg_re_i | input | 1 | One-cycle read strobe |
| reg_addr_i | input | 4 | Word address {window, field} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| cpu_addr_i | input | 32 | CPU address to decode |
| hit_o | output | 3 | One-hot winning window |
| offset_o | output | 32 | Byte offset into the winning window |

## Verification
Read data is due one cycle after the read strobe. The hit and offset are due in the same cycle as the address once a write has committed, which is one edge after the write strobe. Each stimulus task pushes its expected item with the bench cycle number on which the result is due. A negedge monitor compares each item only on that cycle, so every sample falls midway between edges, after the register that feeds it has settled. Window edges, the inverted-write retention, the remap copy and the overlap order are all checked this way.

// File: rtl/adw_pkg.sv
package adw_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int GRAN_W  = 21;
  localparam int LOW_W   = 15;
  localparam int HIGH_W  = 7;
  localparam int REMAP_W = 11;
  localparam int NUM_WIN = 3;

  typedef enum logic [1:0] {
    FLD_LOW   = 2'd0,
    FLD_HIGH  = 2'd1,
    FLD_REMAP = 2'd2,
    FLD_NONE  = 2'd3
  } field_e;

  function automatic logic [LOW_W-1:0] rst_low(int idx);
    case (idx)
      0:       return LOW_W'(32'h80);
      1:       return LOW_W'(32'h90);
      default: return LOW_W'(32'h790);
    endcase
  endfunction

  function automatic logic [HIGH_W-1:0] rst_high(int idx);
    return (idx == 0) ? HIGH_W'(32'h0f) : HIGH_W'(32'h1f);
  endfunction
endpackage

// File: rtl/adw_window.sv
module adw_window #(
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 21,
  parameter int LOW_W   = 15,
  parameter int HIGH_W  = 7,
  parameter int REMAP_W = 11,
  parameter int DATA_W  = 32,
  parameter logic [LOW_W-1:0]  LOW_RST  = '0,
  parameter logic [HIGH_W-1:0] HIGH_RST = '0,
  localparam int UNIT_W = ADDR_W - GRAN_W,
  localparam int LEN_W  = HIGH_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               low_we_i,
  input  logic               high_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [UNIT_W-1:0]  cpu_unit_i,
  output logic [LOW_W-1:0]   low_o,
  output logic [HIGH_W-1:0]  high_o,
  output logic [REMAP_W-1:0] remap_o,
  output logic               hit_o,
  output logic [UNIT_W-1:0]  off_unit_o
);
  localparam logic [UNIT_W-1:0] BASE_RST = LOW_RST[UNIT_W-1:0];
  localparam logic [LEN_W-1:0]  LEN_RST  =
    LEN_W'(HIGH_RST) + LEN_W'(1) - LEN_W'(LOW_RST[HIGH_W-1:0]);

  logic [LOW_W-1:0]  low_q, low_d;
  logic [HIGH_W-1:0] high_q, high_d;
  logic [REMAP_W-1:0] remap_q;
  logic [UNIT_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              valid_d, upd;
  logic [UNIT_W:0]   end_unit;

  always_comb begin
    low_d   = low_we_i  ? wdata_i[LOW_W-1:0]  : low_q;
    high_d  = high_we_i ? wdata_i[HIGH_W-1:0] : high_q;
    valid_d = low_d[HIGH_W-1:0] <= high_d;
    len_d   = LEN_W'(high_d) + LEN_W'(1) - LEN_W'(low_d[HIGH_W-1:0]);
    upd     = (low_we_i || high_we_i) && valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= LOW_RST;
      high_q  <= HIGH_RST;
      remap_q <= LOW_RST[REMAP_W-1:0];
      base_q  <= BASE_RST;
      len_q   <= LEN_RST;
    end else begin
      low_q  <= low_d;
      high_q <= high_d;
      if (low_we_i) remap_q <= wdata_i[REMAP_W-1:0];
      if (upd) begin
        base_q <= low_d[UNIT_W-1:0];
        len_q  <= len_d;
      end
    end
  end

  // one extra bit so a window may end exactly at the top of the space
  assign end_unit   = {1'b0, base_q} + (UNIT_W+1)'(len_q);
  assign hit_o      = ({1'b0, cpu_unit_i} >= {1'b0, base_q}) &&
                      ({1'b0, cpu_unit_i} <  end_unit);
  assign off_unit_o = cpu_unit_i - base_q;
  assign low_o      = low_q;
  assign high_o     = high_q;
  assign remap_o    = remap_q;
endmodule

// File: rtl/adw_prio.sv
module adw_prio #(
  parameter int NUM_WIN = 3,
  parameter int UNIT_W  = 11
) (
  input  logic [NUM_WIN-1:0]             hit_i,
  input  logic [NUM_WIN-1:0][UNIT_W-1:0] off_i,
  output logic [NUM_WIN-1:0]             grant_o,
  output logic [UNIT_W-1:0]              off_o
);
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    off_o   = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit_i[w] && !taken) begin
        grant_o[w] = 1'b1;
        off_o      = off_i[w];
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import adw_pkg::*;
#(
  localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int RA_W   = WSEL_W + 2,
  localparam int UNIT_W = ADDR_W - GRAN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [RA_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  output logic [NUM_WIN-1:0] hit_o,
  output logic [ADDR_W-1:0]  offset_o
);
  logic [WSEL_W-1:0] wsel;
  field_e            fsel;
  logic [NUM_WIN-1:0][LOW_W-1:0]   low_q;
  logic [NUM_WIN-1:0][HIGH_W-1:0]  high_q;
  logic [NUM_WIN-1:0][REMAP_W-1:0] remap_q;
  logic [NUM_WIN-1:0]              win_hit;
  logic [NUM_WIN-1:0][UNIT_W-1:0]  win_off;
  logic [UNIT_W-1:0]               sel_off;
  logic [UNIT_W-1:0]               cpu_unit;
  logic [DATA_W-1:0]               rd_d, rdata_q;

  assign wsel     = reg_addr_i[RA_W-1:2];
  assign fsel     = field_e'(reg_addr_i[1:0]);
  assign cpu_unit = cpu_addr_i[ADDR_W-1:GRAN_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel_w;
    assign sel_w = reg_we_i && (wsel == WSEL_W'(w));
    adw_window #(
      .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
      .REMAP_W(REMAP_W), .DATA_W(DATA_W),
      .LOW_RST(rst_low(w)), .HIGH_RST(rst_high(w))
    ) u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .low_we_i   (sel_w && fsel == FLD_LOW),
      .high_we_i  (sel_w && fsel == FLD_HIGH),
      .wdata_i    (reg_wdata_i),
      .cpu_unit_i (cpu_unit),
      .low_o      (low_q[w]),
      .high_o     (high_q[w]),
      .remap_o    (remap_q[w]),
      .hit_o      (win_hit[w]),
      .off_unit_o (win_off[w])
    );
  end

  adw_prio #(.NUM_WIN(NUM_WIN), .UNIT_W(UNIT_W)) u_prio (
    .hit_i   (win_hit),
    .off_i   (win_off),
    .grant_o (hit_o),
    .off_o   (sel_off)
  );

  assign offset_o = (|hit_o) ? {sel_off, cpu_addr_i[GRAN_W-1:0]} : '0;

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (wsel == WSEL_W'(w)) begin
        case (fsel)
          FLD_LOW:   rd_d = DATA_W'(low_q[w]);
          FLD_HIGH:  rd_d = DATA_W'(high_q[w]);
          FLD_REMAP: rd_d = DATA_W'(remap_q[w]);
          default:   rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_d;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/adw_checker.sv
module adw_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int GRAN_W  = 21,
  parameter int NUM_WIN = 3,
  parameter int RA_W    = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_re_i,
  input logic [RA_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [ADDR_W-1:0]  cpu_addr_i,
  input logic [NUM_WIN-1:0] hit_o,
  input logic [ADDR_W-1:0]  offset_o
);
  // R7: one window at most
  p_hit_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));

  // R8: quiet outputs on a miss
  p_miss_offset_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == '0) |-> (offset_o == '0));

  // R5: offset keeps the in-unit address bits
  p_offset_low_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |-> (offset_o[GRAN_W-1:0] == cpu_addr_i[GRAN_W-1:0]));

  // R8: read data holds without a read strobe
  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o));

  // R8: unused field reads zero
  p_unused_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i[1:0] == 2'd3) |=> (reg_rdata_o == '0));

  // R2: stored bounds are masked
  p_low_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i[1:0] == 2'd0) |=> (reg_rdata_o[DATA_W-1:15] == '0));
  p_high_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i[1:0] == 2'd1) |=> (reg_rdata_o[DATA_W-1:7] == '0));

  // R3: remap copy is masked
  p_remap_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i[1:0] == 2'd2) |=> (reg_rdata_o[DATA_W-1:11] == '0));
endmodule

bind addr_window_decoder adw_checker #(
  .ADDR_W(adw_pkg::ADDR_W), .DATA_W(adw_pkg::DATA_W), .GRAN_W(adw_pkg::GRAN_W),
  .NUM_WIN(adw_pkg::NUM_WIN), .RA_W(RA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cpu_addr_i  (cpu_addr_i),
  .hit_o       (hit_o),
  .offset_o    (offset_o)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] cpu_addr = '0, offset;
  logic [2:0]  hit;

  always #4 clk = ~clk;

  addr_window_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_addr_i(cpu_addr), .hit_o(hit), .offset_o(offset)
  );

  typedef struct {
    int          due;
    bit          is_read;
    logic [31:0] exp_d;
    logic [2:0]  exp_hit;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (it.due != cyc) begin
        n_fail++;
        $display("FAIL %s: missed sample slot (due %0d, now %0d)", it.tag, it.due, cyc);
      end else if (it.is_read) begin
        if (reg_rdata !== it.exp_d) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.exp_d);
        end
      end else if (hit !== it.exp_hit || offset !== it.exp_d) begin
        n_fail++;
        $display("FAIL %s: hit=%b off=%h expected hit=%b off=%h",
                 it.tag, hit, offset, it.exp_hit, it.exp_d);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_we = 1'b0;
    reg_re = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step();
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    step();
    reg_addr = a; reg_re = 1'b1;
    it.due = cyc + 1; it.is_read = 1; it.exp_d = e; it.exp_hit = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic probe(input logic [31:0] a, input logic [2:0] eh,
                       input logic [31:0] eo, input string tag);
    item_t it;
    step();
    cpu_addr = a;
    it.due = cyc; it.is_read = 0; it.exp_d = eo; it.exp_hit = eh; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents
    rd(4'h0, 32'h80,  "R1 io low");
    rd(4'h1, 32'h0f,  "R1 io high");
    rd(4'h2, 32'h80,  "R1 io remap");
    rd(4'h4, 32'h90,  "R1 mem0 low");
    rd(4'h5, 32'h1f,  "R1 mem0 high");
    rd(4'h6, 32'h90,  "R1 mem0 remap");
    rd(4'h8, 32'h790, "R1 mem1 low");
    rd(4'h9, 32'h1f,  "R1 mem1 high");
    rd(4'ha, 32'h790, "R1 mem1 remap");
    rd(4'h3, 32'h0,   "R8 unused field");
    rd(4'hc, 32'h0,   "R8 unused window");

    // R5 reset windows, edges
    probe(32'h0fff_ffff, 3'b000, 32'h0,        "R8 below io");
    probe(32'h1000_0000, 3'b001, 32'h0,        "R5 io first");
    probe(32'h11ff_ffff, 3'b001, 32'h01ff_ffff,"R5 io last");
    probe(32'h1200_0000, 3'b010, 32'h0,        "R5 mem0 first");
    probe(32'h13ff_ffff, 3'b010, 32'h01ff_ffff,"R5 mem0 last");
    probe(32'h1400_0000, 3'b000, 32'h0,        "R5 mem0 past end");
    probe(32'hf1ff_ffff, 3'b000, 32'h0,        "R5 below mem1");
    probe(32'hf200_0000, 3'b100, 32'h0,        "R4 mem1 first, upper low bits");
    probe(32'hf3ff_ffff, 3'b100, 32'h01ff_ffff,"R5 mem1 last");
    probe(32'hf400_0000, 3'b000, 32'h0,        "R5 mem1 past end");

    // R2/R6 masked low write that inverts the window
    wr(4'h0, 32'hffff_8123);
    rd(4'h0, 32'h123, "R2 low mask");
    rd(4'h2, 32'h123, "R3 remap loaded");
    probe(32'h1000_0000, 3'b001, 32'h0, "R6 io retained after inverted low");
    wr(4'h1, 32'hffff_ffaa);
    rd(4'h1, 32'h2a, "R2 high mask");
    rd(4'h2, 32'h123, "R3 remap untouched by high write");
    probe(32'h1000_0000, 3'b000, 32'h0,         "R9 old io gone");
    probe(32'h2460_0000, 3'b001, 32'h0,         "R9 io new first");
    probe(32'h255f_ffff, 3'b001, 32'h00ff_ffff, "R5 io new last");
    probe(32'h2560_0000, 3'b000, 32'h0,         "R5 io new past end");

    // R3 remap writes ignored
    wr(4'h2, 32'h5);
    rd(4'h2, 32'h123, "R3 remap write ignored");

    // R4 upper low bits ignored for length
    wr(4'h8, 32'h0000_7f85);
    rd(4'h8, 32'h7f85, "R2 low keeps 15 bits");
    rd(4'ha, 32'h785,  "R3 remap 11 bits");
    probe(32'hf09f_ffff, 3'b000, 32'h0,         "R4 below mem1");
    probe(32'hf0a0_0000, 3'b100, 32'h0,         "R4 mem1 first");
    probe(32'hf3ff_ffff, 3'b100, 32'h035f_ffff, "R4 mem1 last");
    probe(32'hf400_0000, 3'b000, 32'h0,         "R4 mem1 past end");

    // window up to the top of the space
    wr(4'h9, 32'h7f);
    probe(32'hffff_ffff, 3'b100, 32'h0f5f_ffff, "R5 mem1 to top");

    // R7 overlaps
    wr(4'h5, 32'h2a);
    wr(4'h4, 32'h123);
    wr(4'h8, 32'h120);
    probe(32'h2460_0000, 3'b001, 32'h0,         "R7 io over mem0, mem1");
    probe(32'h2400_0000, 3'b100, 32'h0,         "R7 mem1 alone");
    wr(4'h1, 32'h23);
    probe(32'h2480_0000, 3'b010, 32'h0020_0000, "R7 mem0 over mem1");
    probe(32'h2560_0000, 3'b100, 32'h0160_0000, "R7 mem1 past mem0");

    // R6 inverted via high write
    wr(4'h1, 32'h10);
    rd(4'h1, 32'h10, "R6 high stored");
    probe(32'h2460_0000, 3'b001, 32'h0,         "R6 io retained after inverted high");
    probe(32'h2480_0000, 3'b010, 32'h0020_0000, "R6 io span retained");

    step();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    if (q.size() != 0) begin
      n_fail += q.size();
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule